// File: doc/BRIEF.md
# Cache Line State Policy Unit

This block is the tag-and-state controller of a second-level cache. It decides which coherence state (Invalid, Shared, Exclusive, Modified) a line takes when it is filled, and how each processor access is handled. A small direct-mapped array holds one entry per index. Each entry has an address tag, a two-bit state and a read-only flag. Data storage, snooping, victim write-back and bus arbitration sit in other blocks.

Each request arrives with a one-cycle `req_valid` strobe. It carries the address, a read/write flag, a lock flag, a page write-through hint and a code/data flag. The memory bus supplies two per-access qualifiers with the request: a write-through indication and a read-only indication. One cycle later the unit returns a registered result. The result gives hit or miss, whether the access must go out on the memory bus, whether the cache data array must be written, whether the first-level cache may keep the data, and the requested line's state and read-only flag after the access.

Two kinds of hint hold lines out of the private states. The page hint comes from the processor and the write-through indication comes from the bus. Read-only lines never take writes into the cache. Locked cycles always reach the bus.

Top module: `l2_state_policy`

## Requirements
- R1: After reset every entry is Invalid with its read-only flag clear, so the first read of any address reports a miss. While reset is held, `rsp_valid` is low.
- R2: A read miss with no hint active fills the line in Exclusive (state code 2). The result shows hit=0, forward=1, data-update=1 and L1-enable=1. A later read of the same address hits with forward=0 and update=0.
- R3: A read miss with the page write-through hint or the bus write-through indication active fills the line in Shared (state code 1), never Exclusive or Modified.
- R4: The page hint and the bus write-through indication have no effect on hits to Exclusive or Modified lines, and the bus indication leaves no mark on the entry.
- R5: A read miss with the bus read-only indication active fills the line in Shared with its read-only flag set.
- R6: A write hit to a read-only line is forwarded to the bus with data-update=0. The line stays Shared with its read-only flag still set.
- R7: On a fill of, or a read hit to, a read-only line, L1-enable equals the code flag: 1 for code fetches and 0 for data reads. Reads of lines that are not read-only return L1-enable=1. Writes always return L1-enable=0.
- R8: Every locked access has forward=1. A locked write hit also updates the data and leaves the line state unchanged (write-through handling).
- R9: A write hit to a Shared line that is not read-only has forward=1 and update=1, and the line stays Shared.
- R10: A write hit to an Exclusive line that is not locked moves the line to Modified (code 3) with forward=0 and update=1. A write hit to a Modified line stays Modified with forward=0.
- R11: A write miss has forward=1 and update=0, reports state Invalid (code 0) and allocates nothing, so a later read of that address misses.
- R12: The result appears with `rsp_valid` high exactly one clock after a cycle with `req_valid` high. `rsp_valid` is low after an idle cycle.
- R13: The entry index is address bits [OFF_W+IDX_W-1:OFF_W] and the tag is the bits above them. A fill to an index held under another tag replaces that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Locked (atomic) cycle |
| req_pwt | input | 1 | Page write-through hint from the processor |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| bus_wt | input | 1 | Bus write-through indication, this access only |
| bus_ro | input | 1 | Bus read-only indication for a fill |
| rsp_valid | output | 1 | Result valid |
| rsp_hit | output | 1 | Access hit a valid entry |
| rsp_fwd_bus | output | 1 | Access must run on the memory bus |
| rsp_upd_data | output | 1 | Cache data array is to be written |
| rsp_l1_en | output | 1 | First-level cache may keep the data |
| rsp_state | output | 2 | Line state after the access (0 I, 1 S, 2 E, 3 M) |
| rsp_ro | output | 1 | Line read-only flag after the access |

## Verification
The hardest cases to reach from the ports are the ones that need a particular history on one entry. Examples are a write-through hint arriving on an access to an Exclusive line, and a write that lands on a line already marked read-only. The stimulus table is ordered so that each such case follows the fill that set the entry up. A conflicting tag on a used index then shows replacement, and a reset in the middle of the run shows that the stored state is cleared.

// File: rtl/l2sp_pkg.sv
package l2sp_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_e;

  // State a freshly filled line receives.
  function automatic mesi_e fill_state(input logic pwt, input logic wt, input logic ro);
    return (pwt || wt || ro) ? ST_S : ST_E;
  endfunction

  // Upper-level caching is allowed unless the line is read-only data.
  function automatic logic l1_allow(input logic ro, input logic code);
    return !ro || code;
  endfunction

endpackage

// File: rtl/l2sp_tag_array.sv
module l2sp_tag_array
  import l2sp_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output mesi_e            lk_state,
  output logic             lk_ro,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  mesi_e            wr_state,
  input  logic             wr_ro
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES*TAG_W-1:0] tag_flat;
  logic [ENTRIES*2-1:0]     st_flat;
  logic [ENTRIES-1:0]       ro_flat;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic [TAG_W-1:0] tag_q;
    mesi_e            st_q;
    logic             ro_q;
    logic             sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q <= '0;
        st_q  <= ST_I;
        ro_q  <= 1'b0;
      end else if (sel) begin
        tag_q <= wr_tag;
        st_q  <= wr_state;
        ro_q  <= wr_ro;
      end
    end
    assign tag_flat[i*TAG_W +: TAG_W] = tag_q;
    assign st_flat[i*2 +: 2]          = st_q;
    assign ro_flat[i]                 = ro_q;
  end

  logic [TAG_W-1:0] rd_tag;
  mesi_e            rd_state;
  assign rd_tag   = tag_flat[lk_idx*TAG_W +: TAG_W];
  assign rd_state = mesi_e'(st_flat[lk_idx*2 +: 2]);

  assign lk_hit   = (rd_state != ST_I) && (rd_tag == lk_tag);
  assign lk_state = lk_hit ? rd_state : ST_I;
  assign lk_ro    = lk_hit && ro_flat[lk_idx];

  AST_RO_ONLY_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_ro |-> wr_state == ST_S) else $error("read-only line stored outside Shared"); // R5

endmodule

// File: rtl/l2sp_policy.sv
module l2sp_policy
  import l2sp_pkg::*;
(
  input  logic  hit,
  input  mesi_e cur_state,
  input  logic  cur_ro,
  input  logic  is_write,
  input  logic  is_lock,
  input  logic  pwt,
  input  logic  is_code,
  input  logic  wt_hint,
  input  logic  ro_hint,
  output logic  fwd,
  output logic  upd,
  output logic  l1_en,
  output logic  store,
  output mesi_e nxt_state,
  output logic  nxt_ro
);
  always_comb begin
    fwd       = 1'b0;
    upd       = 1'b0;
    l1_en     = 1'b0;
    store     = 1'b0;
    nxt_state = ST_I;
    nxt_ro    = 1'b0;
    if (!is_write) begin
      if (hit) begin
        fwd       = is_lock;
        l1_en     = l1_allow(cur_ro, is_code);
        nxt_state = cur_state;
        nxt_ro    = cur_ro;
      end else begin
        fwd       = 1'b1;
        upd       = 1'b1;
        store     = 1'b1;
        nxt_state = fill_state(pwt, wt_hint, ro_hint);
        nxt_ro    = ro_hint;
        l1_en     = l1_allow(ro_hint, is_code);
      end
    end else if (!hit) begin
      fwd = 1'b1;
    end else begin
      store     = 1'b1;
      nxt_state = cur_state;
      nxt_ro    = cur_ro;
      if (cur_ro) begin
        fwd = 1'b1;
      end else if (is_lock || cur_state == ST_S) begin
        fwd = 1'b1;
        upd = 1'b1;
      end else begin
        upd       = 1'b1;
        nxt_state = ST_M;
      end
    end
  end

endmodule

// File: rtl/l2_state_policy.sv
module l2_state_policy
  import l2sp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic              req_pwt,
  input  logic              req_code,
  input  logic              bus_wt,
  input  logic              bus_ro,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_fwd_bus,
  output logic              rsp_upd_data,
  output logic              rsp_l1_en,
  output logic [1:0]        rsp_state,
  output logic              rsp_ro
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  assign a_idx = req_addr[OFF_W +: IDX_W];
  assign a_tag = req_addr[ADDR_W-1 -: TAG_W];

  logic  lk_hit, lk_ro;
  mesi_e lk_state;
  logic  pol_fwd, pol_upd, pol_l1, pol_store, pol_ro;
  mesi_e pol_state;

  // Named events for the assertions.
  logic ev_fill, ev_wr_ro_hit, ev_wr_excl_hit;
  assign ev_fill        = req_valid && !req_write && !lk_hit;
  assign ev_wr_ro_hit   = req_valid && req_write && lk_hit && lk_ro;
  assign ev_wr_excl_hit = req_valid && req_write && lk_hit && lk_state == ST_E && !req_lock;

  l2sp_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_idx   (a_idx),
    .lk_tag   (a_tag),
    .lk_hit   (lk_hit),
    .lk_state (lk_state),
    .lk_ro    (lk_ro),
    .wr_en    (req_valid && pol_store),
    .wr_idx   (a_idx),
    .wr_tag   (a_tag),
    .wr_state (pol_state),
    .wr_ro    (pol_ro)
  );

  l2sp_policy u_policy (
    .hit       (lk_hit),
    .cur_state (lk_state),
    .cur_ro    (lk_ro),
    .is_write  (req_write),
    .is_lock   (req_lock),
    .pwt       (req_pwt),
    .is_code   (req_code),
    .wt_hint   (bus_wt),
    .ro_hint   (bus_ro),
    .fwd       (pol_fwd),
    .upd       (pol_upd),
    .l1_en     (pol_l1),
    .store     (pol_store),
    .nxt_state (pol_state),
    .nxt_ro    (pol_ro)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_fwd_bus  <= 1'b0;
      rsp_upd_data <= 1'b0;
      rsp_l1_en    <= 1'b0;
      rsp_state    <= ST_I;
      rsp_ro       <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= lk_hit;
        rsp_fwd_bus  <= pol_fwd;
        rsp_upd_data <= pol_upd;
        rsp_l1_en    <= pol_l1;
        rsp_state    <= pol_state;
        rsp_ro       <= pol_ro;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid) else $error("missing response"); // R12
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid) else $error("spurious response"); // R12
  AST_LOCK_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_lock |=> rsp_fwd_bus) else $error("locked cycle kept off bus"); // R8
  AST_HINT_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill && (req_pwt || bus_wt) |-> pol_state == ST_S) else $error("hinted fill not Shared"); // R3
  AST_RO_WRITE_MEMONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ro_hit |-> pol_fwd && !pol_upd) else $error("read-only write touched data"); // R6
  AST_EXCL_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_excl_hit |=> rsp_state == ST_M && !rsp_fwd_bus) else $error("exclusive write mishandled"); // R10

endmodule

// File: tb/tb_l2_state_policy.sv
`timescale 1ns/1ps
module tb_l2_state_policy;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0, req_lock = 1'b0, req_pwt = 1'b0, req_code = 1'b0;
  logic        bus_wt = 1'b0, bus_ro = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fwd_bus, rsp_upd_data, rsp_l1_en, rsp_ro;
  logic [1:0]  rsp_state;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  l2_state_policy dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_lock(req_lock), .req_pwt(req_pwt), .req_code(req_code),
    .bus_wt(bus_wt), .bus_ro(bus_ro), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_fwd_bus(rsp_fwd_bus), .rsp_upd_data(rsp_upd_data), .rsp_l1_en(rsp_l1_en),
    .rsp_state(rsp_state), .rsp_ro(rsp_ro)
  );

  // Vector: addr, {write,lock,pwt,code,wt,ro}, {hit,fwd,upd,l1}, state, ro
  localparam int NV = 20;
  localparam logic [28:0] VEC [NV] = '{
    {16'h1000, 6'b000000, 4'b0111, 2'd2, 1'b0}, // R2 plain fill -> E
    {16'h1000, 6'b000000, 4'b1001, 2'd2, 1'b0}, // R2 read hit
    {16'h1000, 6'b101010, 4'b1010, 2'd3, 1'b0}, // R4 R10 hints ignored, E->M
    {16'h1000, 6'b100000, 4'b1010, 2'd3, 1'b0}, // R10 M stays M
    {16'h1020, 6'b001000, 4'b0111, 2'd1, 1'b0}, // R3 page hint fill -> S
    {16'h1020, 6'b100000, 4'b1110, 2'd1, 1'b0}, // R9 write hit S
    {16'h1040, 6'b000010, 4'b0111, 2'd1, 1'b0}, // R3 bus hint fill -> S
    {16'h1040, 6'b000000, 4'b1001, 2'd1, 1'b0}, // R4 read hit, no lasting mark
    {16'h1060, 6'b000001, 4'b0110, 2'd1, 1'b1}, // R5 R7 read-only data fill
    {16'h1060, 6'b000000, 4'b1000, 2'd1, 1'b1}, // R7 ro data read hit
    {16'h1060, 6'b000100, 4'b1001, 2'd1, 1'b1}, // R7 ro code read hit
    {16'h1060, 6'b100000, 4'b1100, 2'd1, 1'b1}, // R6 write to ro line
    {16'h1060, 6'b000100, 4'b1001, 2'd1, 1'b1}, // R6 still ro S
    {16'h1080, 6'b100000, 4'b0100, 2'd0, 1'b0}, // R11 write miss
    {16'h1080, 6'b000000, 4'b0111, 2'd2, 1'b0}, // R11 no allocation
    {16'h1080, 6'b110000, 4'b1110, 2'd2, 1'b0}, // R8 locked write hit E
    {16'h1080, 6'b010000, 4'b1101, 2'd2, 1'b0}, // R8 locked read hit
    {16'h2000, 6'b000000, 4'b0111, 2'd2, 1'b0}, // R13 conflicting tag
    {16'h1000, 6'b000000, 4'b0111, 2'd2, 1'b0}, // R13 replaced line misses
    {16'h10A0, 6'b000101, 4'b0111, 2'd1, 1'b1}  // R7 read-only code fill
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input logic [5:0] f);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    {req_write, req_lock, req_pwt, req_code, bus_wt, bus_ro} = f;
    @(negedge clk);
    req_valid = 1'b0;
    {req_write, req_lock, req_pwt, req_code, bus_wt, bus_ro} = '0;
  endtask

  function automatic logic [6:0] got();
    return {rsp_hit, rsp_fwd_bus, rsp_upd_data, rsp_l1_en, rsp_state, rsp_ro};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid low", {6'd0, rsp_valid}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle no response", {6'd0, rsp_valid}, 7'd0);
    access(16'h3000, 6'b000000);
    check("R1 first read misses", {got()}, {4'b0111, 2'd2, 1'b0});
    check("R12 response valid", {6'd0, rsp_valid}, 7'd1);
    @(negedge clk);
    check("R12 gone after idle", {6'd0, rsp_valid}, 7'd0);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][28:13], VEC[i][12:7]);
      check($sformatf("vector %0d (see table tag)", i), got(), VEC[i][6:0]);
    end
    // R1: reset mid-run clears held lines
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    access(16'h1020, 6'b000000);
    check("R1 cleared after reset", got(), {4'b0111, 2'd2, 1'b0});
    access(16'h1060, 6'b000000);
    check("R1 ro flag cleared", got(), {4'b0111, 2'd2, 1'b0});
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule